// File: doc/BRIEF.md
# 1-Wire Search Triplet Sequencer

This block carries out one step of the 1-Wire ROM search. A single start strobe, together with a preferred branch bit, makes it run three bit slots on a bit-level bus engine. The first slot reads the ID bit and the second reads its complement. The third slot writes the chosen branch back, and it is skipped when no device answered. When the step is finished, the block raises `done_o` for one cycle and presents a 3-bit result. The result holds both sampled bits and the branch that was taken.

Each slot starts with a one-cycle `slot_go_o` pulse, with `slot_wr_o` giving its kind. The block then waits for that slot's own completion flag. If the flag does not arrive within a parameterised number of cycles, the step is abandoned and the result reports that no device answered. The search state across all 64 bits belongs to the caller, and the pulse timing on the wire belongs to the bus engine.

Top module: `trip_seq`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `slot_go_o` are all 0.
- R2: The slots run in a fixed order: read (`slot_wr_o`=0), read, then write (`slot_wr_o`=1). Each slot gets exactly one `slot_go_o` pulse, and the next pulse comes in the cycle after the previous slot's completion flag is sampled.
- R3: If both sampled bits are 1, the result is 3'b011 and no write slot is issued.
- R4: If both sampled bits are 0, the branch is the `dir_i` value captured with the accepted start. That bit is written, and the result is 3'b100 for branch 1 or 3'b000 for branch 0.
- R5: If exactly one sampled bit is 1, the branch is forced to the ID bit. That bit is written, and the result is 3'b101 or 3'b010.
- R6: The result fields are: bit 0 is the ID bit, bit 1 is the complement bit, bit 2 is the branch.
- R7: A read slot completes only on `rx_done_i`, and a write slot completes only on `tx_done_i`. The other flag has no effect on that slot.
- R8: The timeout counter restarts with every slot. A slot whose flag has not been sampled after TIMEOUT_CYC cycles ends the step with result 3'b011, and no further slot is issued. A flag sampled exactly at cycle TIMEOUT_CYC is still accepted.
- R9: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after an accepted start until `done_o` rises.
- R10: A start strobe while `busy_o` is high is ignored. It does not change the slot sequence, the timing or the branch used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one search step (accepted only when idle) |
| dir_i | input | 1 | Preferred branch, captured with the start |
| slot_go_o | output | 1 | One-cycle request to start a bit slot |
| slot_wr_o | output | 1 | Slot kind: 1 write, 0 read |
| slot_wbit_o | output | 1 | Bit to write in a write slot |
| rx_done_i | input | 1 | Read slot complete; `rx_bit_i` valid |
| rx_bit_i | input | 1 | Bit sampled by the read slot |
| tx_done_i | input | 1 | Write slot complete |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 3 | {branch, complement bit, ID bit} |

## Verification
The bench's bus model answers each slot D cycles after its `slot_go_o` pulse. With D, a full step ends with `done_o` visible 3(D+1) cycles after the start edge. A step with no responding device ends after 2(D+1) cycles. A step abandoned at slot k ends after k(D+1)+TIMEOUT_CYC cycles. The bench counts cycles from the edge that samples the start, and it compares the cycle in which `done_o` appears against these formulas. It then checks that `done_o` has dropped one cycle later. All inputs are driven and all outputs are sampled on the falling edge, so every sample falls exactly between the registers that produce it.

// File: rtl/trip_pkg.sv
package trip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR     = 2'd3
    } st_e;

    // result when no device answered or a slot timed out
    localparam logic [2:0] RES_NONE = 3'b011;

    typedef struct packed {
        st_e        st;
        logic       go;
        logic       wr;
        logic       wbit;
        logic       pref;
        logic       idb;
        logic       cmpb;
        logic       done;
        logic [2:0] res;
    } seq_s;

endpackage

// File: rtl/trip_timer.sv
module trip_timer #(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // the wait has lasted TIMEOUT_CYC cycles at this edge
    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/trip_decide.sv
module trip_decide
    import trip_pkg::*;
(
    input  logic       id_bit_i,
    input  logic       cmp_bit_i,
    input  logic       pref_i,
    output logic       no_slave_o,
    output logic       dir_o,
    output logic [2:0] res_o
);
    always_comb begin
        no_slave_o = id_bit_i & cmp_bit_i;
        if (id_bit_i ^ cmp_bit_i) begin
            dir_o = id_bit_i;
        end else if (no_slave_o) begin
            dir_o = 1'b0;
        end else begin
            dir_o = pref_i;
        end
        res_o = no_slave_o ? RES_NONE : {dir_o, cmp_bit_i, id_bit_i};
    end

endmodule

// File: rtl/trip_seq.sv
module trip_seq
    import trip_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       dir_i,
    output logic       slot_go_o,
    output logic       slot_wr_o,
    output logic       slot_wbit_o,
    input  logic       rx_done_i,
    input  logic       rx_bit_i,
    input  logic       tx_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] result_o
);
    seq_s       s_d, s_q;
    logic       expired;
    logic       flag;
    logic       no_slave;
    logic       dir_pick;
    logic [2:0] res_pick;

    // each wait state listens to its own completion flag only
    assign flag = (s_q.st == ST_WR) ? tx_done_i : rx_done_i;

    trip_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (s_d.go),
        .run_i    (s_q.st != ST_IDLE),
        .expired_o(expired)
    );

    trip_decide u_decide (
        .id_bit_i  (s_q.idb),
        .cmp_bit_i (rx_bit_i),
        .pref_i    (s_q.pref),
        .no_slave_o(no_slave),
        .dir_o     (dir_pick),
        .res_o     (res_pick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.go   = 1'b0;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st   = ST_RD_ID;
                    s_d.go   = 1'b1;
                    s_d.wr   = 1'b0;
                    s_d.pref = dir_i;
                end
            end
            ST_RD_ID: begin
                if (flag) begin
                    s_d.idb = rx_bit_i;
                    s_d.st  = ST_RD_CMP;
                    s_d.go  = 1'b1;
                end else if (expired) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.res  = RES_NONE;
                end
            end
            ST_RD_CMP: begin
                if (flag) begin
                    s_d.cmpb = rx_bit_i;
                    if (no_slave) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_NONE;
                    end else begin
                        s_d.st   = ST_WR;
                        s_d.go   = 1'b1;
                        s_d.wr   = 1'b1;
                        s_d.wbit = dir_pick;
                        s_d.res  = res_pick;
                    end
                end else if (expired) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.res  = RES_NONE;
                end
            end
            ST_WR: begin
                if (flag) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.wr   = 1'b0;
                end else if (expired) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.wr   = 1'b0;
                    s_d.res  = RES_NONE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, res: RES_NONE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_go_o   = s_q.go;
    assign slot_wr_o   = s_q.wr;
    assign slot_wbit_o = s_q.wbit;
    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = s_q.done;
    assign result_o    = s_q.res;

endmodule

// File: rtl/trip_seq_chk.sv
module trip_seq_chk #(
    parameter int TIMEOUT_CYC = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       slot_go_o,
    input logic       slot_wr_o,
    input logic       slot_wbit_o,
    input logic       rx_done_i,
    input logic       tx_done_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [2:0] result_o
);
    int   wait_cnt;
    logic wr_seen;
    logic wbit_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt  <= 0;
            wr_seen   <= 1'b0;
            wbit_seen <= 1'b0;
        end else begin
            if (slot_go_o) begin
                wait_cnt <= 0;
            end else if (busy_o && !rx_done_i && !tx_done_i) begin
                wait_cnt <= wait_cnt + 1;
            end
            if (start_i && !busy_o) begin
                wr_seen <= 1'b0;
            end else if (slot_go_o && slot_wr_o) begin
                wr_seen   <= 1'b1;
                wbit_seen <= slot_wbit_o;
            end
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r2_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go_o |=> !slot_go_o);
    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !rx_done_i && !tx_done_i) |=> !slot_go_o);
    a_r5_forced_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (result_o[0] != result_o[1])) |-> (result_o[2] == result_o[0]));
    a_r3_none_branch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o[1:0] == 2'b11) |-> !result_o[2]);
    a_r6_reported_written: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o != 3'b011) |-> (wr_seen && result_o[2] == wbit_seen));
    a_r8_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (wait_cnt < TIMEOUT_CYC));

endmodule

bind trip_seq trip_seq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .slot_go_o  (slot_go_o),
    .slot_wr_o  (slot_wr_o),
    .slot_wbit_o(slot_wbit_o),
    .rx_done_i  (rx_done_i),
    .tx_done_i  (tx_done_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/trip_seq_bench.sv
module trip_seq_bench;
    localparam int TMO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       dir_i = 1'b0;
    logic       slot_go_o, slot_wr_o, slot_wbit_o;
    logic       rx_done_i = 1'b0;
    logic       rx_bit_i = 1'b0;
    logic       tx_done_i = 1'b0;
    logic       busy_o, done_o;
    logic [2:0] result_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    trip_seq #(.TIMEOUT_CYC(TMO)) u_trip_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .slot_go_o(slot_go_o), .slot_wr_o(slot_wr_o), .slot_wbit_o(slot_wbit_o),
        .rx_done_i(rx_done_i), .rx_bit_i(rx_bit_i), .tx_done_i(tx_done_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // bus model: answers each slot rsp_dly falling edges after its go pulse
    bit   rsp_id, rsp_cmp, rsp_spur;
    int   rsp_dly = 1;
    int   drop_slot = -1;
    int   pend = 0;
    int   slot_n = 0;
    int   cur_idx = 0;
    logic cur_wr = 1'b0;
    logic kinds [4];
    logic wseen = 1'b0;

    always @(negedge clk) begin
        rx_done_i = 1'b0;
        tx_done_i = 1'b0;
        rx_bit_i  = 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                if (cur_wr) tx_done_i = 1'b1;
                else begin
                    rx_done_i = 1'b1;
                    rx_bit_i  = (cur_idx == 0) ? rsp_id : rsp_cmp;
                end
            end else if (rsp_spur && pend == rsp_dly - 1) begin
                if (cur_wr) rx_done_i = 1'b1;
                else        tx_done_i = 1'b1;
            end
        end
        if (slot_go_o) begin
            cur_idx = slot_n;
            cur_wr  = slot_wr_o;
            if (slot_n < 4) kinds[slot_n] = slot_wr_o;
            if (slot_wr_o) wseen = slot_wbit_o;
            if (slot_n != drop_slot) pend = rsp_dly;
            slot_n = slot_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // run one step; restart_at >= 0 pulses start again that many cycles in
    task automatic run_step(input bit i_id, input bit i_cmp, input bit i_dir,
                            input int dly, input bit spur, input int drop,
                            input int restart_at,
                            output logic [2:0] res, output int lat,
                            output int nsl, output bit busy_mid,
                            output bit done_after);
        rsp_id = i_id; rsp_cmp = i_cmp; rsp_dly = dly; rsp_spur = spur;
        drop_slot = drop; slot_n = 0; wseen = 1'b0;
        for (int k = 0; k < 4; k++) kinds[k] = 1'bx;
        dir_i   = i_dir;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i  = 1'b0;
        dir_i    = ~i_dir;
        lat      = 0;
        busy_mid = busy_o;
        while (!done_o && lat < 300) begin
            start_i = (lat == restart_at);
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        if (lat >= 300) chk(1'b0, "watchdog step", lat, 0);
        res = result_o;
        nsl = slot_n;
        @(posedge clk);
        @(negedge clk);
        done_after = done_o;
    endtask

    typedef struct packed {
        logic       id;
        logic       cmp;
        logic       dir;
        logic [3:0] dly;
        logic       spur;
        logic [2:0] res;
        logic [1:0] nsl;
        logic       wbit;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 3'b000, 2'd3, 1'b0},
        '{1'b0, 1'b0, 1'b1, 4'd2, 1'b0, 3'b100, 2'd3, 1'b1},
        '{1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 3'b101, 2'd3, 1'b1},
        '{1'b0, 1'b1, 1'b1, 4'd3, 1'b0, 3'b010, 2'd3, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'd1, 1'b0, 3'b011, 2'd2, 1'b0},
        '{1'b1, 1'b0, 1'b0, 4'd7, 1'b0, 3'b101, 2'd3, 1'b1},
        '{1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 3'b100, 2'd3, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog global", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] res;
        int lat, nsl;
        bit bm, da;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done_o == 1'b0, "R1 done at reset", done_o, 0);
        chk(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
        chk(slot_go_o == 1'b0, "R1 go at reset", slot_go_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 7; v++) begin
            vec_t t = VECS[v];
            int exp_lat = int'(t.nsl) * (int'(t.dly) + 1);
            run_step(t.id, t.cmp, t.dir, int'(t.dly), t.spur, -1, -1, res, lat, nsl, bm, da);
            if (t.res == 3'b011) chk(res == t.res, "R3 result none", res, t.res);
            else if (t.id ^ t.cmp) chk(res == t.res, "R5 result forced", res, t.res);
            else chk(res == t.res, "R4 result pref", res, t.res);
            if (t.spur) chk(lat == exp_lat, "R7 wrong flag latency", lat, exp_lat);
            else chk(lat == exp_lat, "R2 latency", lat, exp_lat);
            chk(nsl == int'(t.nsl), "R2 R3 slot count", nsl, t.nsl);
            chk(kinds[0] === 1'b0 && kinds[1] === 1'b0, "R2 read slots first", kinds[0], 0);
            if (t.nsl == 2'd3) begin
                chk(kinds[2] === 1'b1, "R2 third slot writes", kinds[2], 1);
                chk(wseen == t.wbit, "R4 R5 written bit", wseen, t.wbit);
                chk(res[1:0] == {t.cmp, t.id}, "R6 sampled fields", res[1:0], {t.cmp, t.id});
                chk(res[2] == t.wbit, "R6 branch field", res[2], t.wbit);
            end
            chk(bm == 1'b1, "R9 busy during step", bm, 1);
            chk(da == 1'b0, "R9 done one cycle", da, 0);
        end

        // R8 timeout at each slot
        run_step(1'b0, 1'b0, 1'b1, 1, 1'b0, 0, -1, res, lat, nsl, bm, da);
        chk(res == 3'b011, "R8 slot0 timeout result", res, 3);
        chk(lat == TMO, "R8 slot0 timeout latency", lat, TMO);
        chk(nsl == 1, "R8 slot0 no further slot", nsl, 1);
        run_step(1'b0, 1'b0, 1'b1, 1, 1'b0, 1, -1, res, lat, nsl, bm, da);
        chk(res == 3'b011, "R8 slot1 timeout result", res, 3);
        chk(lat == 2 + TMO, "R8 slot1 timeout latency", lat, 2 + TMO);
        chk(nsl == 2, "R8 slot1 no further slot", nsl, 2);
        run_step(1'b0, 1'b1, 1'b1, 1, 1'b0, 2, -1, res, lat, nsl, bm, da);
        chk(res == 3'b011, "R8 write timeout result", res, 3);
        chk(lat == 4 + TMO, "R8 write timeout latency", lat, 4 + TMO);
        chk(da == 1'b0, "R9 done one cycle after timeout", da, 0);

        // R10 start while busy ignored
        run_step(1'b0, 1'b0, 1'b0, 2, 1'b0, -1, 1, res, lat, nsl, bm, da);
        chk(res == 3'b000, "R10 result unchanged", res, 0);
        chk(lat == 9, "R10 latency unchanged", lat, 9);
        chk(nsl == 3, "R10 slot count unchanged", nsl, 3);
        chk(wseen == 1'b0, "R10 branch not recaptured", wseen, 0);
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0 && slot_n == 3, "R10 no extra step", slot_n, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule